// File: doc/BRIEF.md
# Oscillator Trim Controller Disciplined by a Pulse-per-Second Reference

This block trims a voltage-controlled reference oscillator so that it follows an external pulse-per-second reference. The block's own clock is the oscillator being trimmed. The reference input is sampled on that clock and must be synchronous to it. A detector classifies the reference from the spacing of its rising edges. Edges about one expected interval apart mark a pulse-per-second reference. Closely spaced edges mark a fast (10 MHz-class) reference. While either class is held, a validity flag stays up.

With a valid pulse-per-second reference, each well-timed edge starts a fixed loop: measure, capture, error, adjustment, output value, apply. The error is the oscillator cycle count between edges minus the expected count. It is scaled down by a host-selected power of two. It is then subtracted from the current DAC code, and the result is clamped to the DAC range. The new code goes to a serial DAC. If the pulses stop, nothing changes, and the last code is held. Lock is lost only when an edge arrives outside the allowed window.

A host can read the applied code at any time. While the block is unlocked, the host can write a cached code, which is sent to the DAC at once. This gives a warm start when the board comes up without a reference.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset, ref_valid, ref_pps and ref_fast are 0, spi_cs_n is 1, spi_sclk is 0, and dac_code is mid-scale (2^(DAC_W-1), 2048 by default).
- R2: An interval is the number of clock cycles between two sampled rising edges of ref_in. When an interval lies within EXPECTED±WINDOW inclusive, the block leaves the unlocked state, and ref_valid=1 and ref_pps=1 from the clock edge after the closing rising edge.
- R3: When an interval is FAST_MAX cycles or fewer, the block leaves the unlocked state, with ref_valid=1, ref_fast=1 and ref_pps=0. An interval longer than FAST_MAX while in fast mode clears ref_valid.
- R4: While locked, the absence of rising edges, however long, changes neither ref_valid nor dac_code.
- R5: In pulse-per-second mode, an edge whose interval is below EXPECTED-WINDOW or above EXPECTED+WINDOW clears ref_valid and ref_pps on the next clock edge. That edge is taken as the first edge of a new search.
- R6: Each in-window edge in pulse-per-second mode (the locking edge included) replaces dac_code with clamp(dac_code − ((interval − EXPECTED) >>> gain_sh)). The shift is arithmetic. The new code appears within 12 clock cycles.
- R7: The correction saturates at 0 and at 2^DAC_W−1.
- R8: A DAC update is one frame. spi_cs_n is low for the whole frame. The frame carries DAC_W bits, most significant bit first, and each bit is valid at the rising spi_sclk edge. spi_sclk is high and low for SCLK_HALF cycles each. The frame's bits equal dac_code.
- R9: A host write while ref_valid=0 sets dac_code to host_wdata on the next clock edge and is followed by one DAC frame carrying it.
- R10: A host write while ref_valid=1 leaves dac_code unchanged and sends no frame.
- R11: Frames never overlap, and dac_code does not change while spi_cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock that is being trimmed |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference input, synchronous to clk |
| gain_sh | input | GAIN_W | Right shift applied to the count error |
| host_wr | input | 1 | Host write strobe for the cached code |
| host_wdata | input | DAC_W | Code written by the host |
| ref_valid | output | 1 | A reference class is held |
| ref_pps | output | 1 | Reference classified as pulse-per-second |
| ref_fast | output | 1 | Reference classified as fast |
| dac_code | output | DAC_W | Code last applied, readable by the host |
| spi_sclk | output | 1 | Serial DAC clock |
| spi_mosi | output | 1 | Serial DAC data |
| spi_cs_n | output | 1 | Serial DAC select, active low |

## Verification
The hardest behaviour to reach from the ports is the difference between an absent pulse and a mistimed one. The stimulus drives every reference edge at an exact cycle count after the previous one. It holds lock across a silence of three intervals, then places edges one cycle outside each edge of the window, on both sides, and confirms that lock is lost only then. Saturation needs a starting code near a rail, which the controller only reaches slowly by itself. The stimulus therefore preloads a code next to full scale, or next to zero, while unlocked, and then locks with an edge at the far border of the window, so that the locking correction drives the code past the rail.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [1:0] {
    REF_SEARCH = 2'd0,
    REF_PPS    = 2'd1,
    REF_FAST   = 2'd2
  } ref_st_e;

  typedef enum logic [2:0] {
    ST_MEASURE  = 3'd0,
    ST_CAPTURE  = 3'd1,
    ST_CALC_ERR = 3'd2,
    ST_CALC_ADJ = 3'd3,
    ST_CALC_OUT = 3'd4,
    ST_APPLY    = 3'd5
  } loop_st_e;
endpackage

// File: rtl/trim_ref_detect.sv
module trim_ref_detect
  import osc_trim_pkg::*;
#(
  parameter int EXPECTED = 2000,
  parameter int WINDOW   = 8,
  parameter int FAST_MAX = 4,
  parameter int CNT_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  output logic             ref_valid,
  output logic             ref_pps,
  output logic             ref_fast,
  output logic             meas_stb,
  output logic [CNT_W-1:0] meas_cnt
);
  localparam logic [CNT_W-1:0] WIN_LO  = CNT_W'(EXPECTED - WINDOW);
  localparam logic [CNT_W-1:0] WIN_HI  = CNT_W'(EXPECTED + WINDOW);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_MAX);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  ref_st_e          st_q, st_d;
  logic             ref_q;
  logic             have_q, have_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stb_q, stb_d;
  logic [CNT_W-1:0] mcnt_q, mcnt_d;
  logic             valid_q, valid_d;
  logic             rise, in_win, is_fast;

  assign rise    = ref_in & ~ref_q;
  assign in_win  = (cnt_q >= WIN_LO) && (cnt_q <= WIN_HI);
  assign is_fast = (cnt_q <= FAST_LIM);

  always_comb begin
    st_d    = st_q;
    have_d  = have_q | rise;
    stb_d   = 1'b0;
    mcnt_d  = mcnt_q;
    if (rise)                cnt_d = CNT_W'(1);
    else if (cnt_q == CNT_TOP) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + CNT_W'(1);
    if (rise) begin
      unique case (st_q)
        REF_SEARCH: begin
          if (have_q && in_win) begin
            st_d   = REF_PPS;
            stb_d  = 1'b1;
            mcnt_d = cnt_q;
          end else if (have_q && is_fast) begin
            st_d = REF_FAST;
          end
        end
        REF_PPS: begin
          if (in_win) begin
            stb_d  = 1'b1;
            mcnt_d = cnt_q;
          end else begin
            st_d = REF_SEARCH;
          end
        end
        REF_FAST: begin
          if (!is_fast) st_d = REF_SEARCH;
        end
        default: st_d = REF_SEARCH;
      endcase
    end
    valid_d = (st_d != REF_SEARCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= REF_SEARCH;
      ref_q   <= 1'b0;
      have_q  <= 1'b0;
      cnt_q   <= '0;
      stb_q   <= 1'b0;
      mcnt_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ref_q   <= ref_in;
      have_q  <= have_d;
      cnt_q   <= cnt_d;
      stb_q   <= stb_d;
      valid_q <= valid_d;
      if (stb_d) mcnt_q <= mcnt_d;
    end
  end

  assign ref_valid = valid_q;
  assign ref_pps   = (st_q == REF_PPS);
  assign ref_fast  = (st_q == REF_FAST);
  assign meas_stb  = stb_q;
  assign meas_cnt  = mcnt_q;
endmodule

// File: rtl/trim_loop.sv
module trim_loop
  import osc_trim_pkg::*;
#(
  parameter int EXPECTED = 2000,
  parameter int CNT_W    = 12,
  parameter int DAC_W    = 12,
  parameter int GAIN_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              locked,
  input  logic              meas_stb,
  input  logic [CNT_W-1:0]  meas_cnt,
  input  logic [GAIN_W-1:0] gain_sh,
  input  logic              host_wr,
  input  logic [DAC_W-1:0]  host_wdata,
  input  logic              spi_busy,
  output logic              spi_start,
  output logic [DAC_W-1:0]  spi_data,
  output logic [DAC_W-1:0]  code
);
  localparam int ERR_W = CNT_W + 1;
  localparam int SUM_W = DAC_W + ERR_W + 1;
  localparam logic signed [ERR_W-1:0] EXP_S  = ERR_W'(EXPECTED);
  localparam logic signed [SUM_W-1:0] FULL_S = SUM_W'((2 ** DAC_W) - 1);
  localparam logic [DAC_W-1:0]        MID    = DAC_W'(2 ** (DAC_W - 1));

  loop_st_e                st_q, st_d;
  logic [CNT_W-1:0]        cap_q, cap_d;
  logic signed [ERR_W-1:0] err_q, err_d;
  logic signed [ERR_W-1:0] adj_q, adj_d;
  logic [DAC_W-1:0]        new_q, new_d;
  logic [DAC_W-1:0]        code_q, code_d;
  logic                    launched_q, launched_d;
  logic                    hpend_q, hpend_d;
  logic signed [SUM_W-1:0] code_ext, adj_ext, diff;
  logic [DAC_W-1:0]        clamped;

  assign code_ext = {{(SUM_W-DAC_W){1'b0}}, code_q};
  assign adj_ext  = {{(SUM_W-ERR_W){adj_q[ERR_W-1]}}, adj_q};
  assign diff     = code_ext - adj_ext;

  always_comb begin
    if (diff[SUM_W-1])     clamped = '0;
    else if (diff > FULL_S) clamped = {DAC_W{1'b1}};
    else                   clamped = diff[DAC_W-1:0];
  end

  always_comb begin
    st_d       = st_q;
    cap_d      = cap_q;
    err_d      = err_q;
    adj_d      = adj_q;
    new_d      = new_q;
    code_d     = code_q;
    launched_d = launched_q;
    hpend_d    = hpend_q;
    spi_start  = 1'b0;
    unique case (st_q)
      ST_MEASURE: begin
        if (run && meas_stb) begin
          st_d = ST_CAPTURE;
        end else if (hpend_q && !spi_busy) begin
          spi_start = 1'b1;
          hpend_d   = 1'b0;
        end
      end
      ST_CAPTURE: begin
        cap_d = meas_cnt;
        st_d  = ST_CALC_ERR;
      end
      ST_CALC_ERR: begin
        err_d = $signed({1'b0, cap_q}) - EXP_S;
        st_d  = ST_CALC_ADJ;
      end
      ST_CALC_ADJ: begin
        adj_d = err_q >>> gain_sh;
        st_d  = ST_CALC_OUT;
      end
      ST_CALC_OUT: begin
        new_d = clamped;
        st_d  = ST_APPLY;
      end
      ST_APPLY: begin
        if (!launched_q) begin
          if (!spi_busy) begin
            spi_start  = 1'b1;
            code_d     = new_q;
            launched_d = 1'b1;
          end
        end else if (!spi_busy) begin
          launched_d = 1'b0;
          st_d       = ST_MEASURE;
        end
      end
      default: st_d = ST_MEASURE;
    endcase
    if (host_wr && !locked) begin
      code_d  = host_wdata;
      hpend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_MEASURE;
      cap_q      <= '0;
      err_q      <= '0;
      adj_q      <= '0;
      new_q      <= MID;
      code_q     <= MID;
      launched_q <= 1'b0;
      hpend_q    <= 1'b0;
    end else begin
      st_q       <= st_d;
      cap_q      <= cap_d;
      err_q      <= err_d;
      adj_q      <= adj_d;
      new_q      <= new_d;
      code_q     <= code_d;
      launched_q <= launched_d;
      hpend_q    <= hpend_d;
    end
  end

  assign spi_data = (st_q == ST_APPLY) ? new_q : code_q;
  assign code     = code_q;
endmodule

// File: rtl/trim_spi_tx.sv
module trim_spi_tx #(
  parameter int DATA_W    = 12,
  parameter int SCLK_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n
);
  localparam int HC_W  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(SCLK_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic              act_q, act_d;
  logic              ph_q, ph_d;
  logic [HC_W-1:0]   hc_q, hc_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    hc_d  = hc_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    if (!act_q) begin
      if (start) begin
        act_d = 1'b1;
        ph_d  = 1'b0;
        hc_d  = '0;
        bit_d = '0;
        sh_d  = data;
      end
    end else if (hc_q == HC_LAST) begin
      hc_d = '0;
      if (!ph_q) begin
        ph_d = 1'b1;
      end else begin
        ph_d = 1'b0;
        if (bit_q == BIT_LAST) begin
          act_d = 1'b0;
        end else begin
          bit_d = bit_q + BIT_W'(1);
          sh_d  = {sh_q[DATA_W-2:0], 1'b0};
        end
      end
    end else begin
      hc_d = hc_q + HC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= 1'b0;
      hc_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      hc_q  <= hc_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign busy = act_q;
  assign sclk = act_q & ph_q;
  assign mosi = sh_q[DATA_W-1];
  assign cs_n = ~act_q;
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl #(
  parameter int DAC_W     = 12,
  parameter int EXPECTED  = 2000,
  parameter int WINDOW    = 8,
  parameter int FAST_MAX  = 4,
  parameter int SCLK_HALF = 4,
  parameter int GAIN_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic [GAIN_W-1:0] gain_sh,
  input  logic              host_wr,
  input  logic [DAC_W-1:0]  host_wdata,
  output logic              ref_valid,
  output logic              ref_pps,
  output logic              ref_fast,
  output logic [DAC_W-1:0]  dac_code,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              spi_cs_n
);
  localparam int CNT_W = $clog2(EXPECTED + WINDOW + 1) + 1;

  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  logic             meas_stb;
  logic [CNT_W-1:0] meas_cnt;
  logic             spi_busy, spi_start;
  logic [DAC_W-1:0] spi_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  trim_ref_detect #(
    .EXPECTED(EXPECTED), .WINDOW(WINDOW), .FAST_MAX(FAST_MAX), .CNT_W(CNT_W)
  ) u_detect (
    .clk(clk), .rst_n(rst_core_n), .ref_in(ref_in),
    .ref_valid(ref_valid), .ref_pps(ref_pps), .ref_fast(ref_fast),
    .meas_stb(meas_stb), .meas_cnt(meas_cnt)
  );

  trim_loop #(
    .EXPECTED(EXPECTED), .CNT_W(CNT_W), .DAC_W(DAC_W), .GAIN_W(GAIN_W)
  ) u_loop (
    .clk(clk), .rst_n(rst_core_n), .run(ref_valid & ref_pps), .locked(ref_valid),
    .meas_stb(meas_stb), .meas_cnt(meas_cnt), .gain_sh(gain_sh),
    .host_wr(host_wr), .host_wdata(host_wdata), .spi_busy(spi_busy),
    .spi_start(spi_start), .spi_data(spi_data), .code(dac_code)
  );

  trim_spi_tx #(
    .DATA_W(DAC_W), .SCLK_HALF(SCLK_HALF)
  ) u_spi (
    .clk(clk), .rst_n(rst_core_n), .start(spi_start), .data(spi_data),
    .busy(spi_busy), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );
endmodule

// File: rtl/osc_trim_ctrl_chk.sv
module osc_trim_ctrl_chk #(
  parameter int DAC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_in,
  input logic             host_wr,
  input logic             ref_valid,
  input logic             ref_pps,
  input logic             ref_fast,
  input logic [DAC_W-1:0] dac_code,
  input logic             spi_sclk,
  input logic             spi_mosi,
  input logic             spi_cs_n
);
  // R4: with the reference input low there is no rising edge, so lock stays
  a_r4_hold_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_in) |=> ref_valid);

  // R3: the two reference classes never coexist
  a_r3_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_pps, ref_fast}));

  // R8: the serial clock idles low outside a frame
  a_r8_idle_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R8: data holds while the serial clock is high
  a_r8_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R11: code frozen during a frame unless the host wrote it
  a_r11_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && !$past(spi_cs_n) && !$past(host_wr)) |-> $stable(dac_code));
endmodule

bind osc_trim_ctrl osc_trim_ctrl_chk #(.DAC_W(DAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .host_wr(host_wr),
  .ref_valid(ref_valid), .ref_pps(ref_pps), .ref_fast(ref_fast),
  .dac_code(dac_code), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n)
);

// File: tb/osc_trim_ctrl_tb.sv
module osc_trim_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 12;
  localparam int EXP  = 2000;
  localparam int WIN  = 8;
  localparam int FMAX = 4;
  localparam int FULL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ref_in;
  logic [3:0]   gain_sh;
  logic         host_wr;
  logic [W-1:0] host_wdata;
  logic         ref_valid, ref_pps, ref_fast;
  logic [W-1:0] dac_code;
  logic         spi_sclk, spi_mosi, spi_cs_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_trim_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .gain_sh(gain_sh),
    .host_wr(host_wr), .host_wdata(host_wdata), .ref_valid(ref_valid),
    .ref_pps(ref_pps), .ref_fast(ref_fast), .dac_code(dac_code),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit cmp_en = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cyc, m_last, m_st, m_code, m_pnew, m_pleft;
  bit m_prev, m_have, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0; m_last = 0; m_st = 0; m_code = 1 << (W-1);
      m_pnew = 0; m_pleft = 0; m_prev = 0; m_have = 0; m_pend = 0;
    end else begin
      bit rise;
      int iv;
      bit inwin, fastk;
      m_cyc++;
      rise = ref_in && !m_prev;
      m_prev = ref_in;
      if (m_pend) begin
        m_pleft--;
        if (m_pleft == 0) begin m_code = m_pnew; m_pend = 0; end
      end
      if (host_wr && m_st == 0) m_code = host_wdata;
      if (rise) begin
        iv = m_cyc - m_last;
        inwin = m_have && iv >= EXP - WIN && iv <= EXP + WIN;
        fastk = m_have && iv <= FMAX;
        if (m_st == 1 && !inwin) m_st = 0;
        else if (m_st == 2 && !fastk) m_st = 0;
        else if (m_st == 0 && inwin) m_st = 1;
        else if (m_st == 0 && fastk) m_st = 2;
        if (m_st == 1 && inwin) begin
          int nv;
          nv = m_code - ((iv - EXP) >>> gain_sh);
          if (nv < 0) nv = 0;
          if (nv > FULL) nv = FULL;
          m_pnew = nv; m_pend = 1; m_pleft = 12;
        end
        m_have = 1;
        m_last = m_cyc;
      end
    end
  end

  // per-clock comparison and frame observation
  bit seen_frame;
  int fstart;
  int frames = 0;
  int nbits;
  int rx;

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(ref_valid == (m_st != 0), "R2 R5 ref_valid vs model", ref_valid, m_st != 0);
      chk(ref_pps == (m_st == 1), "R2 ref_pps vs model", ref_pps, m_st == 1);
      chk(ref_fast == (m_st == 2), "R3 ref_fast vs model", ref_fast, m_st == 2);
      if (m_pend)
        chk(dac_code == m_code || dac_code == m_pnew, "R6 dac_code in update",
            dac_code, m_pnew);
      else
        chk(dac_code == m_code, "R6 dac_code vs model", dac_code, m_code);
      if (!spi_cs_n) begin
        if (!seen_frame) begin seen_frame = 1; fstart = dac_code; end
        else chk(dac_code == fstart, "R11 code frozen in frame", dac_code, fstart);
      end else begin
        seen_frame = 0;
      end
    end
  end

  always @(posedge spi_sclk) begin
    rx = ((rx << 1) | spi_mosi) & FULL;
    nbits++;
  end
  always @(negedge spi_cs_n) begin
    nbits = 0;
    rx = 0;
  end
  always @(posedge spi_cs_n) begin
    if (cmp_en) begin
      chk(nbits == W, "R8 bits per frame", nbits, W);
      chk(rx == dac_code, "R8 frame payload", rx, dac_code);
      frames++;
    end
  end

  // stimulus helpers: each step sets inputs for the next rising clock edge
  int since = 0;

  task automatic step(bit v, bit hw = 1'b0, int hd = 0);
    @(negedge clk);
    ref_in = v;
    host_wr = hw;
    host_wdata = W'(hd);
    since++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic pps_at(int iv);
    while (since < iv - 1) step(1'b0);
    step(1'b1);
    since = 0;
  endtask

  task automatic host(int v);
    step(1'b0, 1'b1, v);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int fr;
    rst_n = 1'b0; ref_in = 1'b0; host_wr = 1'b0; host_wdata = '0; gain_sh = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    idle(5);
    // R1 reset state
    chk(ref_valid == 0 && ref_pps == 0 && ref_fast == 0, "R1 flags clear", ref_valid, 0);
    chk(dac_code == 2048, "R1 mid-scale code", dac_code, 2048);
    chk(spi_cs_n == 1 && spi_sclk == 0, "R1 serial idle", spi_cs_n, 1);

    // R9 host preload while unlocked
    fr = frames;
    host(3000);
    idle(1);
    chk(dac_code == 3000, "R9 preload applied", dac_code, 3000);
    idle(150);
    chk(frames == fr + 1, "R9 preload frame sent", frames, fr + 1);

    // R2 lock
    pps_at(50);
    pps_at(EXP);
    idle(1);
    chk(ref_valid == 1 && ref_pps == 1, "R2 lock on in-window edge", ref_valid, 1);

    // R6 corrections under several gains
    gain_sh = 4'd0; pps_at(EXP + 5); idle(150);
    chk(dac_code == 2995, "R6 gain0 err+5", dac_code, 2995);
    gain_sh = 4'd1; pps_at(EXP - 6); idle(150);
    chk(dac_code == 2998, "R6 gain1 err-6", dac_code, 2998);
    gain_sh = 4'd2; pps_at(EXP + 7); idle(150);
    chk(dac_code == 2997, "R6 gain2 err+7", dac_code, 2997);
    gain_sh = 4'd1; pps_at(EXP - 7); idle(150);
    chk(dac_code == 3001, "R6 gain1 err-7", dac_code, 3001);

    // R4 absent pulses hold lock and code
    idle(3 * EXP);
    chk(ref_valid == 1, "R4 lock held without pulses", ref_valid, 1);
    chk(dac_code == 3001, "R4 code held", dac_code, 3001);

    // R10 host write ignored while locked
    fr = frames;
    host(100);
    idle(150);
    chk(dac_code == 3001, "R10 locked write ignored", dac_code, 3001);
    chk(frames == fr, "R10 no frame on locked write", frames, fr);

    // R5 late edge after long silence
    pps_at(since + 1);
    idle(1);
    chk(ref_valid == 0, "R5 late edge drops lock", ref_valid, 0);

    // R7 saturation at full scale
    host(FULL - 2);
    gain_sh = 4'd0;
    pps_at(EXP - WIN);
    idle(150);
    chk(ref_valid == 1, "R2 lock at lower window border", ref_valid, 1);
    chk(dac_code == FULL, "R7 clamp at full scale", dac_code, FULL);

    // R5 early edge one outside the window
    pps_at(EXP - WIN - 1);
    idle(1);
    chk(ref_valid == 0, "R5 early edge drops lock", ref_valid, 0);

    // R7 saturation at zero
    host(3);
    pps_at(EXP + WIN);
    idle(150);
    chk(dac_code == 0, "R7 clamp at zero", dac_code, 0);

    // R5 late edge one outside the window
    pps_at(EXP + WIN + 1);
    idle(1);
    chk(ref_valid == 0, "R5 late edge by one drops lock", ref_valid, 0);

    // R3 fast reference
    for (int i = 0; i < 6; i++) pps_at(3);
    idle(1);
    chk(ref_valid == 1 && ref_fast == 1 && ref_pps == 0, "R3 fast class", ref_fast, 1);
    pps_at(20);
    idle(1);
    chk(ref_valid == 0 && ref_fast == 0, "R3 slow edge ends fast lock", ref_valid, 0);

    idle(20);
    done = 1;
    summary();
    $finish;
  end
endmodule